// File: doc/BRIEF.md
# Multi-Rate Lock Search Sequencer

This block is the digital controller of a multi-rate clock-recovery receiver. It drives a frequency sweep around the nominal oscillator frequency and watches a lock indication from the analog loop. Each search cycle has three parts. The sweep offset first ramps upward from the low end of the span to the high end. It then ramps back down. The offset then rests at the low end for a fixed system interval before the next cycle starts. Whenever the lock input is high, the whole search freezes in place.

In auto mode a rate counter steps through five candidate rate codes, one per search cycle. Each code picks a divider modulus of 1, 2 or 4. In manual mode the rate code is taken from an input and held for every cycle. Manual mode can also select a modulus of 8 for the lowest data rates.

Serial data is forced low until the lock has stayed high for a programmable number of clocks, and again whenever the carrier is absent. The recovered clock keeps running whether or not the loop is locked. The clock is gated only by an enable input, which saves power. All sweep timing is given in system clock cycles.

Top module: `rate_search_seq`

## Requirements
- R1: While `rst` is high and after its release, `rate_code_o` is 0, `sweep_up_o` is 1, `sweep_ofs_o` is -SPAN and `locked_o` is 0.
- R2: `sweep_ofs_o` rises by one every STEP_CLKS clocks from -SPAN to +SPAN, with `sweep_up_o` high. It then falls by one every STEP_CLKS clocks back to -SPAN, with `sweep_up_o` low. It never leaves the range -SPAN..+SPAN.
- R3: After the downward ramp ends, the offset rests at -SPAN with `sweep_up_o` low for SYS_CLKS clocks. A new upward ramp then starts, so a full cycle lasts 4*SPAN*STEP_CLKS + SYS_CLKS unfrozen clocks.
- R4: In auto mode (`auto_mode_i` = 1), the rate code advances at the end of each cycle in the order 0,1,2,3,4,0. Codes 5, 6 and 7 are never produced. If the code is one of these when auto mode resumes, the next advance goes to 0.
- R5: In manual mode (`auto_mode_i` = 0), `rate_code_o` equals `rate_code_i` as sampled on the previous clock edge, and the end of a cycle does not change it.
- R6: `div_sel_o` is the base-2 logarithm of the divider modulus. Codes 0 and 1 give 2 (modulus 4), code 2 gives 1 (modulus 2), codes 3 and 4 give 0 (modulus 1), and codes 5 to 7 give 3 (modulus 8). Only codes 5 to 7 give modulus 8, and only manual mode can reach them.
- R7: On every clock edge where `lock_i` is sampled high, the sweep offset, the sweep direction, the cycle position and the auto-mode rate code all hold their values.
- R8: `locked_o` goes high after `lock_i` has been sampled high on LOCK_HOLD consecutive edges. It goes low after the first edge that samples `lock_i` low.
- R9: `sdo_o` equals `data_i` when both `locked_o` and `carrier_i` are high, and is 0 otherwise.
- R10: `sco_o` equals `rclk_i` when `clk_en_i` is high and is 0 otherwise, whatever the lock state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| auto_mode_i | input | 1 | 1 = auto rate search, 0 = manual rate |
| rate_code_i | input | 3 | Manual rate code |
| lock_i | input | 1 | Lock indication from the analog loop |
| carrier_i | input | 1 | Carrier present |
| data_i | input | 1 | Retimed serial data |
| rclk_i | input | 1 | Recovered serial clock |
| clk_en_i | input | 1 | Serial clock output enable |
| rate_code_o | output | 3 | Current rate code |
| div_sel_o | output | 2 | Base-2 logarithm of the divider modulus |
| sweep_up_o | output | 1 | Sweep direction, 1 = upward ramp |
| sweep_ofs_o | output | clog2(SPAN+1)+1 | Signed sweep offset |
| locked_o | output | 1 | Qualified lock |
| sdo_o | output | 1 | Muted serial data |
| sco_o | output | 1 | Gated serial clock |

## Verification
Several properties are checked on every cycle. The offset must stay within its span. The direction may only reverse at the span ends. Auto codes must stay in the valid set, and no auto code may map to modulus 8. A raised lock must hold the sweep and the code. The lock flag must drop as soon as the lock input falls, data must be muted whenever the lock is not qualified, and the clock must be gated by its enable. Other behaviour can only be shown by the bench's scenarios, where a reference model tracks the position in the cycle and compares against it on every clock. These scenarios cover the exact ramp timing and cycle length, the wrap of the rate walk, manual codes loaded one edge later, the return from an invalid manual code to code 0, and a lock glitch shorter than the qualification window.

// File: rtl/rs_pkg.sv
package rs_pkg;

    typedef logic [2:0] rate_code_t;

    typedef enum logic [1:0] {
        PH_UP   = 2'd0,
        PH_DOWN = 2'd1,
        PH_SYS  = 2'd2
    } sweep_ph_e;

    typedef struct packed {
        rate_code_t code;
        logic [1:0] div_log2;
    } rate_sel_t;

    localparam rate_code_t RATE_FIRST = 3'd0;
    localparam rate_code_t RATE_LAST  = 3'd4;

    // Auto walk: valid codes in order, anything at or past the last wraps.
    function automatic rate_code_t next_rate(input rate_code_t c);
        return (c >= RATE_LAST) ? RATE_FIRST : c + 3'd1;
    endfunction

    function automatic logic [1:0] div_of(input rate_code_t c);
        logic [1:0] d;
        case (c)
            3'd0, 3'd1: d = 2'd2;
            3'd2:       d = 2'd1;
            3'd3, 3'd4: d = 2'd0;
            default:    d = 2'd3;
        endcase
        return d;
    endfunction

endpackage

// File: rtl/rs_sweep_gen.sv
module rs_sweep_gen
    import rs_pkg::*;
#(
    parameter int SPAN      = 10,
    parameter int STEP_CLKS = 4,
    parameter int SYS_CLKS  = 16
) (
    input  logic                             clk,
    input  logic                             rst,
    input  logic                             freeze_i,
    output sweep_ph_e                        phase_o,
    output logic signed [$clog2(SPAN+1):0]   ofs_o,
    output logic                             cycle_end_o
);
    localparam int OFS_W = $clog2(SPAN + 1) + 1;
    localparam int PRE_W = $clog2(STEP_CLKS + 1);
    localparam int SYS_W = $clog2(SYS_CLKS + 1);
    localparam logic signed [OFS_W-1:0] OFS_HI    = OFS_W'(SPAN);
    localparam logic signed [OFS_W-1:0] OFS_LO    = -OFS_HI;
    localparam logic signed [OFS_W-1:0] OFS_ONE   = OFS_W'(1);
    localparam logic signed [OFS_W-1:0] OFS_HI_M1 = OFS_HI - OFS_ONE;
    localparam logic signed [OFS_W-1:0] OFS_LO_P1 = OFS_LO + OFS_ONE;
    localparam logic [PRE_W-1:0] PRE_LAST = PRE_W'(STEP_CLKS - 1);
    localparam logic [SYS_W-1:0] SYS_LAST = SYS_W'(SYS_CLKS - 1);

    sweep_ph_e               phase;
    logic signed [OFS_W-1:0] ofs;
    logic [PRE_W-1:0]        pre;
    logic [SYS_W-1:0]        sys;
    logic                    tick;

    assign tick = (pre == PRE_LAST);

    always_ff @(posedge clk) begin
        if (rst) begin
            phase <= PH_UP;
            ofs   <= OFS_LO;
            pre   <= '0;
            sys   <= '0;
        end else if (!freeze_i) begin
            unique case (phase)
                PH_UP: begin
                    if (tick) begin
                        pre <= '0;
                        ofs <= ofs + OFS_ONE;
                        if (ofs == OFS_HI_M1) phase <= PH_DOWN;
                    end else begin
                        pre <= pre + PRE_W'(1);
                    end
                end
                PH_DOWN: begin
                    if (tick) begin
                        pre <= '0;
                        ofs <= ofs - OFS_ONE;
                        if (ofs == OFS_LO_P1) phase <= PH_SYS;
                    end else begin
                        pre <= pre + PRE_W'(1);
                    end
                end
                PH_SYS: begin
                    if (sys == SYS_LAST) begin
                        sys   <= '0;
                        phase <= PH_UP;
                    end else begin
                        sys <= sys + SYS_W'(1);
                    end
                end
                default: phase <= PH_UP;
            endcase
        end
    end

    assign phase_o     = phase;
    assign ofs_o       = ofs;
    assign cycle_end_o = !freeze_i && (phase == PH_SYS) && (sys == SYS_LAST);

endmodule

// File: rtl/rs_rate_ctr.sv
module rs_rate_ctr
    import rs_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       auto_i,
    input  rate_code_t man_code_i,
    input  logic       advance_i,
    output rate_sel_t  sel_o
);
    rate_code_t code;

    always_ff @(posedge clk) begin
        if (rst)            code <= RATE_FIRST;
        else if (!auto_i)   code <= man_code_i;
        else if (advance_i) code <= next_rate(code);
    end

    assign sel_o.code     = code;
    assign sel_o.div_log2 = div_of(code);

endmodule

// File: rtl/rs_lock_qual.sv
module rs_lock_qual #(
    parameter int LOCK_HOLD = 8
) (
    input  logic clk,
    input  logic rst,
    input  logic lock_i,
    output logic locked_o
);
    localparam int HW = $clog2(LOCK_HOLD + 1);
    localparam logic [HW-1:0] HOLD_MAX = HW'(LOCK_HOLD);

    logic [HW-1:0] streak;

    always_ff @(posedge clk) begin
        if (rst || !lock_i)        streak <= '0;
        else if (streak != HOLD_MAX) streak <= streak + HW'(1);
    end

    assign locked_o = (streak == HOLD_MAX);

endmodule

// File: rtl/rate_search_seq.sv
module rate_search_seq
    import rs_pkg::*;
#(
    parameter int SPAN      = 10,
    parameter int STEP_CLKS = 4,
    parameter int SYS_CLKS  = 16,
    parameter int LOCK_HOLD = 8
) (
    input  logic                           clk,
    input  logic                           rst,
    input  logic                           auto_mode_i,
    input  logic [2:0]                     rate_code_i,
    input  logic                           lock_i,
    input  logic                           carrier_i,
    input  logic                           data_i,
    input  logic                           rclk_i,
    input  logic                           clk_en_i,
    output logic [2:0]                     rate_code_o,
    output logic [1:0]                     div_sel_o,
    output logic                           sweep_up_o,
    output logic signed [$clog2(SPAN+1):0] sweep_ofs_o,
    output logic                           locked_o,
    output logic                           sdo_o,
    output logic                           sco_o
);
    sweep_ph_e phase;
    logic      cycle_end;
    rate_sel_t sel;
    logic      qualified;

    rs_sweep_gen #(
        .SPAN(SPAN), .STEP_CLKS(STEP_CLKS), .SYS_CLKS(SYS_CLKS)
    ) u_sweep (
        .clk(clk), .rst(rst), .freeze_i(lock_i),
        .phase_o(phase), .ofs_o(sweep_ofs_o), .cycle_end_o(cycle_end)
    );

    rs_rate_ctr u_rate (
        .clk(clk), .rst(rst), .auto_i(auto_mode_i),
        .man_code_i(rate_code_i), .advance_i(cycle_end), .sel_o(sel)
    );

    rs_lock_qual #(.LOCK_HOLD(LOCK_HOLD)) u_lock (
        .clk(clk), .rst(rst), .lock_i(lock_i), .locked_o(qualified)
    );

    assign rate_code_o = sel.code;
    assign div_sel_o   = sel.div_log2;
    assign sweep_up_o  = (phase == PH_UP);
    assign locked_o    = qualified;
    assign sdo_o       = data_i & qualified & carrier_i;
    assign sco_o       = rclk_i & clk_en_i;

endmodule

// File: rtl/rs_seq_chk.sv
module rs_seq_chk #(
    parameter int SPAN = 10
) (
    input logic                           clk,
    input logic                           rst,
    input logic                           auto_mode_i,
    input logic [2:0]                     rate_code_i,
    input logic                           lock_i,
    input logic                           carrier_i,
    input logic                           clk_en_i,
    input logic [2:0]                     rate_code_o,
    input logic [1:0]                     div_sel_o,
    input logic                           sweep_up_o,
    input logic signed [$clog2(SPAN+1):0] sweep_ofs_o,
    input logic                           locked_o,
    input logic                           sdo_o,
    input logic                           sco_o
);
    p_ofs_range_r2: assert property (@(posedge clk) disable iff (rst)
        ($signed(sweep_ofs_o) <= SPAN) && ($signed(sweep_ofs_o) >= -SPAN));

    p_turn_top_r2: assert property (@(posedge clk) disable iff (rst)
        $fell(sweep_up_o) |-> ($signed(sweep_ofs_o) == SPAN));

    p_restart_low_r3: assert property (@(posedge clk) disable iff (rst)
        $rose(sweep_up_o) |-> ($signed(sweep_ofs_o) == -SPAN));

    p_auto_valid_r4: assert property (@(posedge clk) disable iff (rst)
        (auto_mode_i && rate_code_o <= 3'd4) |=> (rate_code_o <= 3'd4));

    p_manual_load_r5: assert property (@(posedge clk) disable iff (rst)
        !auto_mode_i |=> (rate_code_o == $past(rate_code_i)));

    p_auto_no_div8_r6: assert property (@(posedge clk) disable iff (rst)
        (rate_code_o <= 3'd4) |-> (div_sel_o != 2'd3));

    p_freeze_r7: assert property (@(posedge clk) disable iff (rst)
        (lock_i && auto_mode_i) |=>
            ($stable(sweep_ofs_o) && $stable(sweep_up_o) && $stable(rate_code_o)));

    p_lock_drop_r8: assert property (@(posedge clk) disable iff (rst)
        !lock_i |=> !locked_o);

    p_lock_rise_r8: assert property (@(posedge clk) disable iff (rst)
        $rose(locked_o) |-> $past(lock_i));

    p_mute_r9: assert property (@(posedge clk) disable iff (rst)
        !(locked_o && carrier_i) |-> !sdo_o);

    p_clk_gate_r10: assert property (@(posedge clk) disable iff (rst)
        !clk_en_i |-> !sco_o);

endmodule

bind rate_search_seq rs_seq_chk #(.SPAN(SPAN)) u_chk (
    .clk(clk), .rst(rst), .auto_mode_i(auto_mode_i), .rate_code_i(rate_code_i),
    .lock_i(lock_i), .carrier_i(carrier_i), .clk_en_i(clk_en_i),
    .rate_code_o(rate_code_o), .div_sel_o(div_sel_o), .sweep_up_o(sweep_up_o),
    .sweep_ofs_o(sweep_ofs_o), .locked_o(locked_o), .sdo_o(sdo_o), .sco_o(sco_o)
);

// File: tb/rate_search_seq_tb.sv
module rate_search_seq_tb;
    localparam int SPAN = 10;
    localparam int K    = 4;
    localparam int SYS  = 16;
    localparam int HOLD = 8;
    localparam int RAMP = 2 * SPAN * K;
    localparam int CYC  = 2 * RAMP + SYS;

    logic clk = 1'b0;
    logic rst, auto_mode_i, lock_i, carrier_i, data_i, rclk_i, clk_en_i;
    logic [2:0] rate_code_i;
    logic [2:0] rate_code_o;
    logic [1:0] div_sel_o;
    logic sweep_up_o, locked_o, sdo_o, sco_o;
    logic signed [$clog2(SPAN+1):0] sweep_ofs_o;

    int checks = 0;
    int fails  = 0;
    bit done   = 0;

    // reference model state
    int m_t = 0;
    int m_code = 0;
    int m_streak = 0;
    logic [15:0] lf = 16'hACE1;

    always #4 clk = ~clk;

    rate_search_seq #(.SPAN(SPAN), .STEP_CLKS(K), .SYS_CLKS(SYS), .LOCK_HOLD(HOLD)) u_dut (
        .clk(clk), .rst(rst), .auto_mode_i(auto_mode_i), .rate_code_i(rate_code_i),
        .lock_i(lock_i), .carrier_i(carrier_i), .data_i(data_i), .rclk_i(rclk_i),
        .clk_en_i(clk_en_i), .rate_code_o(rate_code_o), .div_sel_o(div_sel_o),
        .sweep_up_o(sweep_up_o), .sweep_ofs_o(sweep_ofs_o), .locked_o(locked_o),
        .sdo_o(sdo_o), .sco_o(sco_o)
    );

    always @(posedge clk) begin
        if (rst) begin
            m_t = 0; m_code = 0; m_streak = 0;
        end else begin
            bit wrap;
            wrap = !lock_i && (m_t == CYC - 1);
            if (lock_i) m_streak = (m_streak < HOLD) ? m_streak + 1 : HOLD;
            else        m_streak = 0;
            if (!lock_i) m_t = wrap ? 0 : m_t + 1;
            if (!auto_mode_i) m_code = int'(rate_code_i);
            else if (wrap)    m_code = (m_code >= 4) ? 0 : m_code + 1;
        end
    end

    function automatic int exp_div(input int c);
        if (c <= 1) return 2;
        if (c == 2) return 1;
        if (c <= 4) return 0;
        return 3;
    endfunction

    function automatic int exp_ofs(input int t);
        if (t <= RAMP)     return -SPAN + t / K;
        if (t <= 2 * RAMP) return SPAN - (t - RAMP) / K;
        return -SPAN;
    endfunction

    task automatic check(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual %0d expected %0d at %0t", req, act, exp, $time);
        end
    endtask

    task automatic compare_all();
        int lk;
        lk = (m_streak == HOLD) ? 1 : 0;
        check(int'(rate_code_o) == m_code, "R4/R5 rate_code", int'(rate_code_o), m_code);
        check(int'(div_sel_o) == exp_div(m_code), "R6 div_sel", int'(div_sel_o), exp_div(m_code));
        check(int'(sweep_ofs_o) == exp_ofs(m_t), "R2/R3/R7 sweep_ofs", int'(sweep_ofs_o), exp_ofs(m_t));
        check(int'(sweep_up_o) == ((m_t < RAMP) ? 1 : 0), "R2/R3/R7 sweep_up",
              int'(sweep_up_o), (m_t < RAMP) ? 1 : 0);
        check(int'(locked_o) == lk, "R8 locked", int'(locked_o), lk);
        check(sdo_o == (data_i & (lk == 1) & carrier_i), "R9 sdo", int'(sdo_o),
              int'(data_i & (lk == 1) & carrier_i));
        check(sco_o == (rclk_i & clk_en_i), "R10 sco", int'(sco_o), int'(rclk_i & clk_en_i));
    endtask

    task automatic step(input int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            compare_all();
            lf = {lf[14:0], lf[15] ^ lf[13] ^ lf[12] ^ lf[10]};
            data_i = lf[0];
            rclk_i = lf[3];
            #1;
            compare_all();
        end
    endtask

    initial begin
        rst = 1; auto_mode_i = 1; rate_code_i = 0; lock_i = 0; carrier_i = 1;
        data_i = 0; rclk_i = 0; clk_en_i = 1;
        step(3);
        rst = 0;
        // R1: reset values
        check(rate_code_o == 3'd0, "R1 code", int'(rate_code_o), 0);
        check(sweep_up_o == 1'b1, "R1 up", int'(sweep_up_o), 1);
        check(int'(sweep_ofs_o) == -SPAN, "R1 ofs", int'(sweep_ofs_o), -SPAN);
        check(locked_o == 1'b0, "R1 locked", int'(locked_o), 0);

        // R2 R3 R4: free auto search through the full walk and its wrap
        step(5 * CYC + 37);
        check(rate_code_o == 3'd0, "R4 wrap to 0", int'(rate_code_o), 0);

        // R8: short lock glitch must not qualify
        lock_i = 1; step(HOLD - 3);
        lock_i = 0; step(2);
        check(locked_o == 1'b0, "R8 glitch", int'(locked_o), 0);

        // R7 R8 R9: sustained lock
        lock_i = 1; step(HOLD + 6);
        check(locked_o == 1'b1, "R8 qualified", int'(locked_o), 1);
        clk_en_i = 0; step(5);           // R10
        clk_en_i = 1;
        carrier_i = 0; step(4);          // R9
        carrier_i = 1; step(3);
        lock_i = 0; step(1);
        check(locked_o == 1'b0, "R8 drop", int'(locked_o), 0);
        step(CYC);

        // R5 R6: manual codes including the modulus 8 set
        auto_mode_i = 0;
        for (int c = 0; c < 8; c++) begin
            rate_code_i = 3'(c);
            step(3);
            check(int'(rate_code_o) == c, "R5 manual load", int'(rate_code_o), c);
            check(int'(div_sel_o) == exp_div(c), "R6 manual div", int'(div_sel_o), exp_div(c));
        end
        rate_code_i = 3'd6;
        step(CYC + 20);
        check(rate_code_o == 3'd6, "R5 manual hold", int'(rate_code_o), 6);

        // R4: back to auto from invalid code
        auto_mode_i = 1;
        step(CYC + 5);
        check(rate_code_o <= 3'd4, "R4 resume valid", int'(rate_code_o), 0);

        // R7 in manual mode with lock
        auto_mode_i = 0; rate_code_i = 3'd7; lock_i = 1;
        step(HOLD + 4);
        lock_i = 0; step(CYC / 2);

        done = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL watchdog actual %0d expected %0d", 1, 0);
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

endmodule